// File: doc/BRIEF.md
# Chunked Memory-Copy DMA Engine

This block is one copy channel. A start pulse samples a staged descriptor made of a config word, a byte count, a source address and a destination address, and checks it in the same cycle. An accepted descriptor is copied into exec registers, which software-visible logic elsewhere can watch. The engine then moves the data one chunk at a time over a simple memory master port. Each chunk is one read followed by one write.

Chunks are a power of two in size, from 1 to 64 bytes. A chunk is held in an internal 64-byte buffer between its read and its write. The engine reports progress through run, done and error flags. A completed descriptor can optionally reload its exec registers, so that the same transfer can be started again.

Top module: `chunk_copy_dma`

## Requirements
- R1: After a synchronous active-low reset, `run_o`, `done_o`, `err_o`, `busy_o` and `mem_req_o` are low, and all exec outputs are zero.
- R2: A start with a byte count of zero sets `err_o`, clears `done_o` and sets `run_o` on the next cycle. It raises no memory request.
- R3: Config encoding: bit 0 is repeat, bits [4:1] are the write size exponent and bits [8:5] are the read size exponent. A start whose two exponents differ is rejected in the same way as R2.
- R4: Chunk size is 2^min(write exponent, 6) bytes, and `mem_size_o` carries min(exponent, 6) on every request.
- R5: A start whose byte count is not a multiple of the chunk size is rejected in the same way as R2.
- R6: On an accepted start, `err_o` and `done_o` clear and `run_o` sets. The exec registers take the staged values, and a read request appears on the next cycle.
- R7: Each chunk is a read at the exec source and then a write (`mem_we_o`=1) at the exec destination. When the write beat is accepted, both addresses grow by the chunk size and the exec byte count shrinks by it.
- R8: Write data holds the read data's low chunk-size bytes; every byte above the chunk is zero.
- R9: When the last write is accepted, `run_o` clears, `done_o` sets and requests stop. Without repeat, the exec byte count ends at zero.
- R10: With repeat set, completion reloads the exec byte count, source and destination with the values sampled at start.
- R11: A start pulse while `busy_o` is high is ignored.
- R12: `mem_err_i` on an accepted beat aborts the transfer. `err_o` sets, `run_o` stays high, and no further request is issued.
- R13: A request is held, with address, direction and size unchanged, until `mem_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; samples the staged descriptor |
| cfg_i | input | 9 | Staged config: repeat, write exponent, read exponent |
| cnt_i | input | CNT_W | Staged byte count |
| src_i | input | ADDR_W | Staged source address |
| dst_i | input | ADDR_W | Staged destination address |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr_o | output | ADDR_W | Beat address |
| mem_size_o | output | 3 | Beat size as log2 bytes |
| mem_wdata_o | output | 512 | Write data, low bytes valid |
| mem_ready_i | input | 1 | Beat accepted this cycle |
| mem_rdata_i | input | 512 | Read data, valid with ready on a read |
| mem_err_i | input | 1 | Error response, valid with ready |
| run_o | output | 1 | Run flag |
| done_o | output | 1 | Done flag |
| err_o | output | 1 | Error flag |
| busy_o | output | 1 | Transfer in progress |
| exec_cfg_o | output | 9 | Latched config |
| exec_bytes_o | output | CNT_W | Bytes remaining |
| exec_src_o | output | ADDR_W | Current source address |
| exec_dst_o | output | ADDR_W | Current destination address |

## Verification
The bench targets the exponent clamp, using an exponent of 8 where 64-byte beats are expected. A design without the clamp would shift past the buffer and send a wrong size. Rejections for zero length, size mismatch and a non-multiple count must raise error without a single beat; a lax check would leak requests. Single-byte repeat transfers must restore their start values, and a start pulse during a transfer must leave the exec config alone. A mid-write error must stop the engine with run still high, and a design that treated it as completion would set done instead.

// File: rtl/chunk_dma_pkg.sv
// Shared types and config field layout for the chunked copy engine.
package chunk_dma_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} dma_state_t;

    localparam int CFG_W       = 9;
    localparam int REPEAT_BIT  = 0;
    localparam int WR_EXP_LSB  = 1;
    localparam int RD_EXP_LSB  = 5;
    localparam int EXP_FIELD_W = 4;

    // Limit a size exponent to the largest supported chunk.
    function automatic logic [EXP_FIELD_W-1:0] clamp_exp(
        input logic [EXP_FIELD_W-1:0] e, input logic [EXP_FIELD_W-1:0] lim);
        return (e > lim) ? lim : e;
    endfunction
endpackage

// File: rtl/dma_desc_check.sv
// Descriptor validation: combinational.
// Assumes the config layout of chunk_dma_pkg; reports acceptance and the clamped exponent.
module dma_desc_check
    import chunk_dma_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int MAX_EXP = 6,
    parameter int EXP_W   = 3
) (
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             ok_o,
    output logic [EXP_W-1:0] exp_o
);
    logic [EXP_FIELD_W-1:0] rd_e, wr_e, lim_e;
    logic [CNT_W-1:0]       rem_mask;

    // Decode exponents, clamp, and test the three rejection conditions.
    always_comb begin
        rd_e     = cfg_i[RD_EXP_LSB +: EXP_FIELD_W];
        wr_e     = cfg_i[WR_EXP_LSB +: EXP_FIELD_W];
        lim_e    = EXP_FIELD_W'(MAX_EXP);
        exp_o    = EXP_W'(clamp_exp(wr_e, lim_e));
        rem_mask = (CNT_W'(1) << exp_o) - CNT_W'(1);
        ok_o     = (cnt_i != '0) && (rd_e == wr_e) && ((cnt_i & rem_mask) == '0);
    end
endmodule

// File: rtl/dma_chunk_buf.sv
// Chunk holding buffer: captures one read beat, zeroing bytes above the chunk.
// Assumes exp_i stays below the buffer's log2 size plus one.
module dma_chunk_buf #(
    parameter int BUF_BYTES = 64,
    parameter int EXP_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [EXP_W-1:0]       exp_i,
    input  logic [8*BUF_BYTES-1:0] rdata_i,
    output logic [8*BUF_BYTES-1:0] data_o
);
    localparam int LIM_W = 32;
    logic [LIM_W-1:0] chunk_len;

    // Number of valid bytes for the current exponent.
    always_comb chunk_len = LIM_W'(1) << exp_i;

    for (genvar g = 0; g < BUF_BYTES; g++) begin : g_byte
        // Capture byte g of the read beat, or zero it when it lies past the chunk.
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_o[8*g +: 8] <= '0;
            else if (load_i)
                data_o[8*g +: 8] <= (LIM_W'(g) < chunk_len) ? rdata_i[8*g +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/chunk_copy_dma.sv
// Chunked memory-copy channel: latch and validate a descriptor, then read/write
// one power-of-two chunk at a time. Assumes the memory port returns read data and
// error together with ready, and that ready may arrive in any later cycle.
module chunk_copy_dma
    import chunk_dma_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 32,
    parameter int MAX_EXP = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start_i,
    input  logic [8:0]                      cfg_i,
    input  logic [CNT_W-1:0]                cnt_i,
    input  logic [ADDR_W-1:0]               src_i,
    input  logic [ADDR_W-1:0]               dst_i,
    output logic                            mem_req_o,
    output logic                            mem_we_o,
    output logic [ADDR_W-1:0]               mem_addr_o,
    output logic [$clog2(MAX_EXP+1)-1:0]    mem_size_o,
    output logic [8*(1<<MAX_EXP)-1:0]       mem_wdata_o,
    input  logic                            mem_ready_i,
    input  logic [8*(1<<MAX_EXP)-1:0]       mem_rdata_i,
    input  logic                            mem_err_i,
    output logic                            run_o,
    output logic                            done_o,
    output logic                            err_o,
    output logic                            busy_o,
    output logic [8:0]                      exec_cfg_o,
    output logic [CNT_W-1:0]                exec_bytes_o,
    output logic [ADDR_W-1:0]               exec_src_o,
    output logic [ADDR_W-1:0]               exec_dst_o
);
    localparam int BUF_BYTES = 1 << MAX_EXP;
    localparam int DATA_W    = 8 * BUF_BYTES;
    localparam int EXP_W     = $clog2(MAX_EXP + 1);

    dma_state_t        state_q;
    logic              run_q, done_q, err_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [CNT_W-1:0]  bytes_q, orig_bytes_q;
    logic [ADDR_W-1:0] src_q, dst_q, orig_src_q, orig_dst_q;
    logic [EXP_W-1:0]  exp_q, chk_exp;
    logic              chk_ok, accept, buf_load, last_chunk;
    logic [CNT_W-1:0]  chunk_cnt;
    logic [ADDR_W-1:0] chunk_adr;
    logic [DATA_W-1:0] buf_data;

    dma_desc_check #(.CNT_W(CNT_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_check (
        .cfg_i(cfg_i), .cnt_i(cnt_i), .ok_o(chk_ok), .exp_o(chk_exp));

    dma_chunk_buf #(.BUF_BYTES(BUF_BYTES), .EXP_W(EXP_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load_i(buf_load), .exp_i(exp_q),
        .rdata_i(mem_rdata_i), .data_o(buf_data));

    // Chunk step, beat acceptance and the last-chunk test.
    always_comb begin
        chunk_cnt  = CNT_W'(1) << exp_q;
        chunk_adr  = ADDR_W'(1) << exp_q;
        accept     = mem_req_o && mem_ready_i;
        buf_load   = (state_q == ST_READ) && mem_ready_i && !mem_err_i;
        last_chunk = (bytes_q == chunk_cnt);
    end

    // Memory port and status outputs.
    always_comb begin
        mem_req_o    = (state_q != ST_IDLE);
        mem_we_o     = (state_q == ST_WRITE);
        mem_addr_o   = (state_q == ST_WRITE) ? dst_q : src_q;
        mem_size_o   = exp_q;
        mem_wdata_o  = buf_data;
        busy_o       = (state_q != ST_IDLE);
        run_o        = run_q;
        done_o       = done_q;
        err_o        = err_q;
        exec_cfg_o   = cfg_q;
        exec_bytes_o = bytes_q;
        exec_src_o   = src_q;
        exec_dst_o   = dst_q;
    end

    // Channel sequencer: start/validate, read beat, write beat, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            run_q        <= 1'b0;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
            cfg_q        <= '0;
            bytes_q      <= '0;
            src_q        <= '0;
            dst_q        <= '0;
            orig_bytes_q <= '0;
            orig_src_q   <= '0;
            orig_dst_q   <= '0;
            exp_q        <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    run_q  <= 1'b1;
                    done_q <= 1'b0;
                    if (chk_ok) begin
                        err_q        <= 1'b0;
                        cfg_q        <= cfg_i;
                        bytes_q      <= cnt_i;
                        src_q        <= src_i;
                        dst_q        <= dst_i;
                        orig_bytes_q <= cnt_i;
                        orig_src_q   <= src_i;
                        orig_dst_q   <= dst_i;
                        exp_q        <= chk_exp;
                        state_q      <= ST_READ;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                ST_READ: if (accept) begin
                    if (mem_err_i) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: if (accept) begin
                    if (mem_err_i) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (last_chunk) begin
                        run_q   <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                        if (cfg_q[REPEAT_BIT]) begin
                            bytes_q <= orig_bytes_q;
                            src_q   <= orig_src_q;
                            dst_q   <= orig_dst_q;
                        end else begin
                            bytes_q <= '0;
                            src_q   <= src_q + chunk_adr;
                            dst_q   <= dst_q + chunk_adr;
                        end
                    end else begin
                        bytes_q <= bytes_q - chunk_cnt;
                        src_q   <= src_q + chunk_adr;
                        dst_q   <= dst_q + chunk_adr;
                        state_q <= ST_READ;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // A waiting beat keeps its request, address, direction and size.
    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                          && $stable(mem_we_o) && $stable(mem_size_o)));

    // Beat size never exceeds the clamp.
    assert_size_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_size_o <= EXP_W'(MAX_EXP)));

    // With error flagged the port is quiet.
    assert_quiet_on_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !mem_req_o);

    // Done only rises together with run falling.
    assert_done_drops_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (!run_o && $fell(run_o)));

    // A start during a transfer leaves the latched config alone.
    assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(exec_cfg_o));

    // While busy the remaining count is non-zero and chunk aligned.
    assert_bytes_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ((exec_bytes_o != '0) && ((exec_bytes_o & (chunk_cnt - CNT_W'(1))) == '0)));
endmodule

// File: tb/chunk_copy_dma_tb_top.sv
`timescale 1ns/1ps
module chunk_copy_dma_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [8:0]   cfg_i = '0;
    logic [31:0]  cnt_i = '0, src_i = '0, dst_i = '0;
    logic         mem_req_o, mem_we_o, mem_ready_i = 1'b0, mem_err_i = 1'b0;
    logic [31:0]  mem_addr_o;
    logic [2:0]   mem_size_o;
    logic [511:0] mem_wdata_o, mem_rdata_i = '0;
    logic         run_o, done_o, err_o, busy_o;
    logic [8:0]   exec_cfg_o;
    logic [31:0]  exec_bytes_o, exec_src_o, exec_dst_o;

    chunk_copy_dma dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i), .cnt_i(cnt_i),
        .src_i(src_i), .dst_i(dst_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o), .mem_wdata_o(mem_wdata_o),
        .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i), .mem_err_i(mem_err_i),
        .run_o(run_o), .done_o(done_o), .err_o(err_o), .busy_o(busy_o),
        .exec_cfg_o(exec_cfg_o), .exec_bytes_o(exec_bytes_o),
        .exec_src_o(exec_src_o), .exec_dst_o(exec_dst_o));

    int vectors = 0, miscompares = 0, cyc = 0;
    string tag = "R1";
    bit chk_en = 0;

    // Behavioural reference state: 0 idle, 1 reading, 2 writing.
    int m_state = 0;
    bit m_run = 0, m_done = 0, m_err = 0;
    logic [8:0] m_cfg = '0;
    logic [31:0] m_bytes = '0, m_src = '0, m_dst = '0, o_bytes = '0, o_src = '0, o_dst = '0;
    int m_sz = 1, m_exp = 0;
    logic [511:0] m_buf = '0;

    // Stimulus requests consumed by the next step.
    bit p_start = 0, p_rst = 1, inj_err = 0;
    logic [8:0] p_cfg = '0;
    logic [31:0] p_cnt = '0, p_src = '0, p_dst = '0;
    int rdy_mode = 0;

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [31:0] t;
        t = a * 32'd13 + 32'd7;
        return t[7:0] ^ a[15:8];
    endfunction

    task automatic chk(input string nm, input logic [511:0] act, input logic [511:0] exp_v);
        vectors++;
        if (act !== exp_v) begin
            miscompares++;
            $display("FAIL %s %s actual %h expected %h", tag, nm, act, exp_v);
        end
    endtask

    task automatic compare_all();
        chk("run", 512'(run_o), 512'(m_run));
        chk("done", 512'(done_o), 512'(m_done));
        chk("err", 512'(err_o), 512'(m_err));
        chk("busy", 512'(busy_o), 512'(m_state != 0));
        chk("req", 512'(mem_req_o), 512'(m_state != 0));
        chk("exec_cfg", 512'(exec_cfg_o), 512'(m_cfg));
        chk("exec_bytes", 512'(exec_bytes_o), 512'(m_bytes));
        chk("exec_src", 512'(exec_src_o), 512'(m_src));
        chk("exec_dst", 512'(exec_dst_o), 512'(m_dst));
        if (m_state != 0) begin
            chk("we", 512'(mem_we_o), 512'(m_state == 2));
            chk("addr", 512'(mem_addr_o), 512'(m_state == 2 ? m_dst : m_src));
            chk("size", 512'(mem_size_o), 512'(m_exp));
            if (m_state == 2) chk("wdata", mem_wdata_o, m_buf);
        end
    endtask

    // One clock: compare at the falling edge, drive, then advance the model.
    task automatic step();
        bit rdy, errin;
        int rd_e, wr_e, e, sz;
        @(negedge clk);
        if (chk_en) compare_all();
        chk_en = 1;
        rst_n   = !p_rst;
        start_i = p_start; cfg_i = p_cfg; cnt_i = p_cnt; src_i = p_src; dst_i = p_dst;
        p_start = 0;
        case (rdy_mode)
            1: rdy = cyc[0];
            2: rdy = (cyc % 3) == 0;
            default: rdy = 1;
        endcase
        errin = inj_err && (m_state == 2) && rdy;
        mem_ready_i = rdy;
        mem_err_i   = errin;
        for (int i = 0; i < 64; i++) mem_rdata_i[8*i +: 8] = mem_byte(m_src + 32'(i));
        if (p_rst) begin
            m_state = 0; m_run = 0; m_done = 0; m_err = 0; m_cfg = '0;
            m_bytes = '0; m_src = '0; m_dst = '0; m_exp = 0; m_sz = 1; m_buf = '0;
        end else begin
            case (m_state)
                0: if (start_i) begin
                    rd_e = int'(cfg_i[8:5]); wr_e = int'(cfg_i[4:1]);
                    e = (wr_e > 6) ? 6 : wr_e; sz = 1 << e;
                    m_run = 1; m_done = 0;
                    if (cnt_i != 0 && rd_e == wr_e && (cnt_i % sz) == 0) begin
                        m_err = 0; m_cfg = cfg_i; m_bytes = cnt_i; m_src = src_i; m_dst = dst_i;
                        o_bytes = cnt_i; o_src = src_i; o_dst = dst_i;
                        m_exp = e; m_sz = sz; m_state = 1;
                    end else m_err = 1;
                end
                1: if (rdy) begin
                    if (errin) begin m_err = 1; m_state = 0; end
                    else begin
                        for (int i = 0; i < 64; i++)
                            m_buf[8*i +: 8] = (i < m_sz) ? mem_rdata_i[8*i +: 8] : 8'h00;
                        m_state = 2;
                    end
                end
                default: if (rdy) begin
                    if (errin) begin m_err = 1; m_state = 0; inj_err = 0; end
                    else begin
                        m_bytes = m_bytes - 32'(m_sz);
                        m_src = m_src + 32'(m_sz); m_dst = m_dst + 32'(m_sz);
                        if (m_bytes == 0) begin
                            m_run = 0; m_done = 1; m_state = 0;
                            if (m_cfg[0]) begin m_bytes = o_bytes; m_src = o_src; m_dst = o_dst; end
                        end else m_state = 1;
                    end
                end
            endcase
        end
        cyc++;
    endtask

    task automatic launch(input logic [8:0] c, input logic [31:0] n, input logic [31:0] s,
                          input logic [31:0] d);
        p_start = 1; p_cfg = c; p_cnt = n; p_src = s; p_dst = d;
        step();
    endtask

    task automatic run_until_idle(input int limit);
        for (int k = 0; k < limit; k++) begin
            step();
            if (m_state == 0) break;
        end
        step(); step();
    endtask

    function automatic logic [8:0] mk_cfg(input bit rep, input int rd, input int wr);
        return {4'(rd), 4'(wr), rep};
    endfunction

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        tag = "R1";
        p_rst = 1; step(); step(); step();
        p_rst = 0; step(); step();

        tag = "R4/R6/R7/R8/R9";          // 4-byte chunks, four of them
        rdy_mode = 0;
        launch(mk_cfg(0, 2, 2), 32'd16, 32'h1000, 32'h8000);
        run_until_idle(100);

        tag = "R4/R8/R13";               // exponent 8 clamps to 64-byte beats
        rdy_mode = 1;
        launch(mk_cfg(0, 8, 8), 32'd128, 32'h2003, 32'h9000);
        run_until_idle(100);

        tag = "R2";                      // zero length
        rdy_mode = 0;
        launch(mk_cfg(0, 1, 1), 32'd0, 32'h10, 32'h20);
        step(); step();

        tag = "R3";                      // read/write size mismatch
        launch(mk_cfg(0, 2, 3), 32'd32, 32'h10, 32'h20);
        step(); step();

        tag = "R5";                      // 12 bytes with 8-byte chunks
        launch(mk_cfg(0, 3, 3), 32'd12, 32'h10, 32'h20);
        step(); step();

        tag = "R6/R10/R13";              // single-byte repeat transfer
        rdy_mode = 2;
        launch(mk_cfg(1, 0, 0), 32'd3, 32'h3000, 32'hA000);
        run_until_idle(100);

        tag = "R11";                     // restart pulses during a transfer
        rdy_mode = 1;
        launch(mk_cfg(0, 4, 4), 32'd64, 32'h4000, 32'hB000);
        step();
        launch(mk_cfg(1, 1, 1), 32'd2, 32'h0, 32'h0);
        step();
        launch(mk_cfg(0, 0, 0), 32'd0, 32'h0, 32'h0);
        run_until_idle(100);

        tag = "R12";                     // error response on a write beat
        rdy_mode = 0;
        launch(mk_cfg(0, 3, 3), 32'd32, 32'h5000, 32'hC000);
        step(); step();
        inj_err = 1;
        run_until_idle(50);
        step(); step();

        tag = "R6";                      // valid restart after an error clears it
        launch(mk_cfg(0, 5, 5), 32'd32, 32'h6000, 32'hD000);
        run_until_idle(50);

        tag = "R1";                      // reset in the middle of a transfer
        launch(mk_cfg(0, 2, 2), 32'd64, 32'h7000, 32'hE000);
        step(); step();
        p_rst = 1; step(); step();
        p_rst = 0; step(); step();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule